// File: doc/BRIEF.md
# CAN Receive Buffer Match Engine

This block sits between the serial receive stage of a CAN controller and the host. When the serial stage hands over a finished, error-free frame, the engine checks the frame against every receive message buffer that is currently enabled. The frame carries an identifier, an extended-format flag, a length, up to eight data bytes and a timestamp that was taken when the identifier field began on the bus. The identifier comparison passes through a global mask. If several buffers qualify, the lowest-numbered one wins. The engine then writes the frame into that buffer in a fixed order. The buffer's state code is updated next, and the buffer's interrupt flag is raised last. If no buffer qualifies, the frame is dropped.

The host sets up a buffer with its own register port. It first writes the code 0000 to park the buffer. It then writes the identifier word. Finally it writes the code for "enabled and empty". The host reads received frames back through the same port. Interrupt flags are cleared by writing ones to them. While the engine updates a buffer, it sets a busy bit in that buffer's code, and the host must not touch the buffer until the bit clears. Frames must reach the engine at least five clock cycles apart.

Top module: `canrx_match_engine`

## Requirements
- R1: After reset, every buffer code reads 0000, the interrupt flags read 0, and the mask register reads all ones (0x1FFFFFFF).
- R2: The host port uses word addresses, shown here for 8 buffers. Buffer n occupies addresses 4n to 4n+3. Word 4n is the control word: code in bits [3:0], length in [11:8], timestamp in [31:16]. Word 4n+1 is the identifier word: identifier in [28:0], extended flag in bit 31. Word 4n+2 holds data bytes 0-3 and word 4n+3 holds bytes 4-7. Address 0x20 is the mask and 0x21 is the interrupt flag register. A host write sets the code or the identifier word, and read data appears one cycle after the address.
- R3: Only buffers whose code is 0100 (empty), 0010 (full) or 0110 (overrun) take part in matching. A buffer with code 0000 never receives a frame.
- R4: A buffer matches when every identifier bit whose mask bit is 1 is equal to the received one and the extended flags are equal. Mask bits of 0 are ignored, and the extended flag is always compared. A standard identifier occupies bits [10:0], with zeros above.
- R5: When several enabled buffers match, the frame goes to the lowest-numbered one and no other buffer changes.
- R6: The chosen buffer receives the received identifier and extended flag, even in masked bit positions. It also receives the length, all eight data bytes, and the timestamp that came with the frame.
- R7: An empty buffer that receives a frame becomes full (0010). A full or overrun buffer that receives a frame becomes overrun (0110).
- R8: A stored frame sets the buffer's bit in the interrupt flag register and on the flag output. A frame that matches nothing changes no flag and no buffer.
- R9: Writing 1 to an interrupt flag bit clears it, and writing 0 leaves it unchanged.
- R10: The frame is accepted on one rising edge. Code bit 0 (busy) is set on the next edge and stays set while the fields are written. The code update follows, and the flag bit is set on the fourth edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a finished frame is present |
| frm_ide | input | 1 | Extended identifier flag of the frame |
| frm_id | input | 29 | Received identifier |
| frm_len | input | 4 | Received length |
| frm_data | input | 64 | Data bytes, byte 0 in bits [7:0] |
| frm_ts | input | TS_W | Timestamp taken at the start of the identifier field |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | AW | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| irq_flags | output | NUM_MB | Per-buffer interrupt flags |

## Verification
The engine is first tried with a standard frame. Its identifier is present in a parked buffer and in two enabled buffers, which separates enable gating from lowest-index selection. The same identifier is then repeated to separate the empty-to-full step from the full-to-overrun step. Two frames that should not match are sent next: one with a wrong identifier and one with a correct identifier but the wrong format flag. These show that a missed match leaves flags and contents untouched. A narrowed mask then lets an extended frame and a standard frame reach buffers whose stored identifiers differ in the ignored bits. This shows that the ignored bits are overwritten, and after a buffer is parked again it shows that the lowest match moves on.

// File: rtl/canrx_pkg.sv
// Shared types and code values for the CAN receive match engine.
// Assumes the receive-code encoding described in the brief (bit 0 = busy).
package canrx_pkg;

    localparam int ID_W   = 29;
    localparam int LEN_W  = 4;
    localparam int DATA_W = 64;

    localparam logic [3:0] CODE_OFF   = 4'b0000;
    localparam logic [3:0] CODE_EMPTY = 4'b0100;
    localparam logic [3:0] CODE_FULL  = 4'b0010;
    localparam logic [3:0] CODE_OVR   = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_STORE,
        ST_CODE,
        ST_FLAG
    } eng_state_t;

    typedef struct packed {
        logic              ide;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    // A buffer takes part in matching when its code is one of the receive states.
    function automatic logic rx_enabled(input logic [3:0] code);
        return (code[3] == 1'b0) && (code[2:1] != 2'b00);
    endfunction

    // The code a buffer moves to once a frame has landed in it.
    function automatic logic [3:0] code_after_rx(input logic [3:0] code);
        logic [3:0] base;
        base = {code[3:1], 1'b0};
        return (base == CODE_EMPTY) ? CODE_FULL : CODE_OVR;
    endfunction

endpackage

// File: rtl/canrx_match_arb.sv
// Compares the held frame against every buffer and picks the lowest match.
// Pure combinational; assumes the inputs are stable during ST_MATCH.
module canrx_match_arb
    import canrx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    localparam int IDX_W  = $clog2(NUM_MB)
) (
    input  logic [ID_W-1:0]               rx_id,
    input  logic                          rx_ide,
    input  logic [ID_W-1:0]               id_mask,
    input  logic [NUM_MB-1:0][ID_W-1:0]   mb_id,
    input  logic [NUM_MB-1:0]             mb_ide,
    input  logic [NUM_MB-1:0][3:0]        mb_code,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    logic [NUM_MB-1:0] match_vec;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_cmp
        // Per-buffer match: enabled, same format, no difference under the mask.
        assign match_vec[i] = rx_enabled(mb_code[i])
                            && (mb_ide[i] == rx_ide)
                            && (((mb_id[i] ^ rx_id) & id_mask) == '0);
    end

    // Lowest-numbered match wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/canrx_rx_ctrl.sv
// Sequencer: holds the incoming frame and steps through match, busy-mark,
// field store, code update and flag set. Assumes frames arrive at least five
// cycles apart; a strobe outside ST_IDLE is not taken.
module canrx_rx_ctrl
    import canrx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    parameter  int TS_W   = 16,
    localparam int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  rx_frame_t         frm_in,
    input  logic [TS_W-1:0]   frm_ts,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    output rx_frame_t         frm_hold,
    output logic [TS_W-1:0]   ts_hold,
    output eng_state_t        state,
    output logic [IDX_W-1:0]  sel,
    output logic              op_busy,
    output logic              op_store,
    output logic              op_code,
    output logic              op_flag
);

    // Capture the frame on acceptance so the serial stage may move on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_hold <= '0;
            ts_hold  <= '0;
        end else if (state == ST_IDLE && frm_valid) begin
            frm_hold <= frm_in;
            ts_hold  <= frm_ts;
        end
    end

    // Step through the store sequence; drop the frame when nothing matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (frm_valid) state <= ST_MATCH;
                ST_MATCH: begin
                    if (hit) begin
                        sel   <= hit_idx;
                        state <= ST_STORE;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_STORE: state <= ST_CODE;
                ST_CODE:  state <= ST_FLAG;
                ST_FLAG:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Strobes towards the buffer store, one per sequence step.
    always_comb begin
        op_busy  = (state == ST_MATCH) && hit;
        op_store = (state == ST_STORE);
        op_code  = (state == ST_CODE);
        op_flag  = (state == ST_FLAG);
    end

endmodule

// File: rtl/canrx_mb_store.sv
// Buffer storage, mask and interrupt flags, with the host register port.
// Engine updates take priority over a host write to the same buffer in the
// same cycle; the host is expected to leave busy buffers alone.
module canrx_mb_store
    import canrx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    parameter  int TS_W   = 16,
    localparam int IDX_W  = $clog2(NUM_MB),
    localparam int MB_AW  = IDX_W + 2,
    localparam int AW     = MB_AW + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         h_wr,
    input  logic [AW-1:0]                h_addr,
    input  logic [31:0]                  h_wdata,
    output logic [31:0]                  h_rdata,
    input  logic [IDX_W-1:0]             sel,
    input  logic                         op_busy,
    input  logic [IDX_W-1:0]             busy_idx,
    input  logic                         op_store,
    input  logic                         op_code,
    input  logic                         op_flag,
    input  rx_frame_t                    frm_hold,
    input  logic [TS_W-1:0]              ts_hold,
    output logic [NUM_MB-1:0][ID_W-1:0]  mb_id,
    output logic [NUM_MB-1:0]            mb_ide,
    output logic [NUM_MB-1:0][3:0]       mb_code,
    output logic [ID_W-1:0]              id_mask,
    output logic [NUM_MB-1:0]            iflag
);

    logic [NUM_MB-1:0][LEN_W-1:0]  mb_len;
    logic [NUM_MB-1:0][DATA_W-1:0] mb_data;
    logic [NUM_MB-1:0][TS_W-1:0]   mb_ts;

    logic              in_mb_space;
    logic [IDX_W-1:0]  a_idx;
    logic [1:0]        a_word;
    logic [31:0]       rd_word;

    assign in_mb_space = !h_addr[AW-1];
    assign a_idx       = h_addr[MB_AW-1:2];
    assign a_word      = h_addr[1:0];

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic wr_ctrl, wr_id, eng_here;

        assign wr_ctrl  = h_wr && in_mb_space && (a_idx == IDX_W'(i)) && (a_word == 2'd0);
        assign wr_id    = h_wr && in_mb_space && (a_idx == IDX_W'(i)) && (a_word == 2'd1);
        assign eng_here = (sel == IDX_W'(i));

        // Code field: busy mark, post-store update, or host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mb_code[i] <= CODE_OFF;
            end else if (op_busy && busy_idx == IDX_W'(i)) begin
                mb_code[i] <= mb_code[i] | 4'b0001;
            end else if (op_code && eng_here) begin
                mb_code[i] <= code_after_rx(mb_code[i]);
            end else if (wr_ctrl) begin
                mb_code[i] <= h_wdata[3:0];
            end
        end

        // Identifier word: received value on store, host value otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mb_id[i]  <= '0;
                mb_ide[i] <= 1'b0;
            end else if (op_store && eng_here) begin
                mb_id[i]  <= frm_hold.id;
                mb_ide[i] <= frm_hold.ide;
            end else if (wr_id) begin
                mb_id[i]  <= h_wdata[ID_W-1:0];
                mb_ide[i] <= h_wdata[31];
            end
        end

        // Payload fields, written only by the engine.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mb_len[i]  <= '0;
                mb_data[i] <= '0;
                mb_ts[i]   <= '0;
            end else if (op_store && eng_here) begin
                mb_len[i]  <= frm_hold.len;
                mb_data[i] <= frm_hold.data;
                mb_ts[i]   <= ts_hold;
            end
        end
    end

    // Global mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mask <= '1;
        end else if (h_wr && !in_mb_space && !h_addr[0]) begin
            id_mask <= h_wdata[ID_W-1:0];
        end
    end

    // Interrupt flags: set by the engine, cleared by host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iflag <= '0;
        end else begin
            iflag <= (iflag & ~((h_wr && !in_mb_space && h_addr[0]) ? h_wdata[NUM_MB-1:0] : '0))
                   | ((op_flag) ? (NUM_MB'(1) << sel) : '0);
        end
    end

    // Read word selection by address.
    always_comb begin
        rd_word = '0;
        if (in_mb_space) begin
            if (int'(a_idx) < NUM_MB) begin
                unique case (a_word)
                    2'd0: rd_word = (32'(mb_ts[a_idx]) << 16) | (32'(mb_len[a_idx]) << 8)
                                  | 32'(mb_code[a_idx]);
                    2'd1: rd_word = {mb_ide[a_idx], 2'b00, mb_id[a_idx]};
                    2'd2: rd_word = mb_data[a_idx][31:0];
                    2'd3: rd_word = mb_data[a_idx][63:32];
                    default: rd_word = '0;
                endcase
            end
        end else if (!h_addr[0]) begin
            rd_word = 32'(id_mask);
        end else begin
            rd_word = 32'(iflag);
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) h_rdata <= '0;
        else        h_rdata <= rd_word;
    end

endmodule

// File: rtl/canrx_match_engine.sv
// Top: ties sequencer, match arbiter and buffer store together.
// Assumes NUM_MB >= 2, TS_W <= 16 and frames spaced at least five cycles.
module canrx_match_engine
    import canrx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    parameter  int TS_W   = 16,
    localparam int AW     = $clog2(NUM_MB) + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  logic               frm_ide,
    input  logic [28:0]        frm_id,
    input  logic [3:0]         frm_len,
    input  logic [63:0]        frm_data,
    input  logic [TS_W-1:0]    frm_ts,
    input  logic               h_wr,
    input  logic [AW-1:0]      h_addr,
    input  logic [31:0]        h_wdata,
    output logic [31:0]        h_rdata,
    output logic [NUM_MB-1:0]  irq_flags
);

    localparam int IDX_W = $clog2(NUM_MB);

    rx_frame_t                   frm_in, frm_hold;
    logic [TS_W-1:0]             ts_hold;
    eng_state_t                  ctrl_state;
    logic [IDX_W-1:0]            eng_sel, hit_idx;
    logic                        hit, op_busy, op_store, op_code, op_flag;
    logic [NUM_MB-1:0][ID_W-1:0] mb_id;
    logic [NUM_MB-1:0]           mb_ide;
    logic [NUM_MB-1:0][3:0]      mb_code_vec;
    logic [ID_W-1:0]             id_mask;

    assign frm_in = '{ide: frm_ide, id: frm_id, len: frm_len, data: frm_data};

    canrx_rx_ctrl #(.NUM_MB(NUM_MB), .TS_W(TS_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_in(frm_in),
        .frm_ts(frm_ts), .hit(hit), .hit_idx(hit_idx), .frm_hold(frm_hold),
        .ts_hold(ts_hold), .state(ctrl_state), .sel(eng_sel), .op_busy(op_busy),
        .op_store(op_store), .op_code(op_code), .op_flag(op_flag)
    );

    canrx_match_arb #(.NUM_MB(NUM_MB)) arb_i (
        .rx_id(frm_hold.id), .rx_ide(frm_hold.ide), .id_mask(id_mask),
        .mb_id(mb_id), .mb_ide(mb_ide), .mb_code(mb_code_vec),
        .hit(hit), .hit_idx(hit_idx)
    );

    canrx_mb_store #(.NUM_MB(NUM_MB), .TS_W(TS_W)) store_i (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .sel(eng_sel), .op_busy(op_busy), .busy_idx(hit_idx),
        .op_store(op_store), .op_code(op_code), .op_flag(op_flag),
        .frm_hold(frm_hold), .ts_hold(ts_hold), .mb_id(mb_id), .mb_ide(mb_ide),
        .mb_code(mb_code_vec), .id_mask(id_mask), .iflag(irq_flags)
    );

endmodule

// File: rtl/canrx_match_engine_chk.sv
// Property checker for the match engine, bound into the top module.
module canrx_match_engine_chk
    import canrx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    localparam int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid,
    input  eng_state_t              eng_state,
    input  logic [IDX_W-1:0]        eng_sel,
    input  logic [NUM_MB-1:0][3:0]  mb_code,
    input  logic [NUM_MB-1:0]       iflag
);

    // Busy bit visible in the chosen buffer while its fields are written (R10).
    assert_busy_during_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_state == ST_STORE |-> mb_code[eng_sel][0]);

    // Frames only arrive when the sequencer is idle (R10 spacing).
    assert_frame_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> eng_state == ST_IDLE);

    // At most one flag rises per cycle (R8).
    assert_single_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iflag & ~$past(iflag)));

    for (genvar i = 0; i < NUM_MB; i++) begin : g_buf
        // Code already shows full/overrun when the flag rises (R7, R10).
        assert_code_before_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iflag[i]) |-> (mb_code[i] == CODE_FULL || mb_code[i] == CODE_OVR));

        // Only a buffer that was enabled at match time can be flagged (R3).
        assert_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iflag[i]) |-> rx_enabled($past(mb_code[i], 4)));
    end

endmodule

bind canrx_match_engine canrx_match_engine_chk #(.NUM_MB(NUM_MB)) chk_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .eng_state(ctrl_state),
    .eng_sel(eng_sel), .mb_code(mb_code_vec), .iflag(irq_flags)
);

// File: tb/canrx_match_engine_tb_top.sv
// Scoreboard bench: the frame driver queues the expected flag event, a
// negedge monitor pops it when a flag rises; host reads check contents.
module canrx_match_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_MB     = 8;
    localparam int TS_W       = 16;
    localparam int AW         = 6;

    typedef struct { int idx; int at; } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_valid = 1'b0, frm_ide = 1'b0;
    logic [28:0]       frm_id = '0;
    logic [3:0]        frm_len = '0;
    logic [63:0]       frm_data = '0;
    logic [TS_W-1:0]   frm_ts = '0;
    logic              h_wr = 1'b0;
    logic [AW-1:0]     h_addr = '0;
    logic [31:0]       h_wdata = '0;
    logic [31:0]       h_rdata;
    logic [NUM_MB-1:0] irq_flags;

    int   errs = 0, checks = 0, cyc = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic [NUM_MB-1:0] prev_flags = '0;

    canrx_match_engine #(.NUM_MB(NUM_MB), .TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ide(frm_ide),
        .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data), .frm_ts(frm_ts),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .irq_flags(irq_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic host_rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); h_addr = a;
        @(negedge clk); d = h_rdata;
    endtask

    task automatic rd_check(string req, logic [AW-1:0] a, logic [31:0] exp);
        logic [31:0] d;
        host_rd(a, d);
        check(req, d, exp);
    endtask

    // Driver: queue the expected flag event, present the frame for one cycle.
    task automatic send_frame(logic ide, logic [28:0] id, logic [3:0] len,
                              logic [63:0] data, logic [15:0] ts, int exp_idx);
        @(negedge clk);
        if (exp_idx >= 0) exp_q.push_back('{idx: exp_idx, at: cyc + 5});
        frm_valid = 1'b1; frm_ide = ide; frm_id = id; frm_len = len;
        frm_data = data; frm_ts = ts;
        @(negedge clk); frm_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Monitor: each newly risen flag must match the head of the queue, on time.
    always @(negedge clk) begin
        logic [NUM_MB-1:0] rose;
        rose = irq_flags & ~prev_flags;
        prev_flags = irq_flags;
        if (rst_n && rose != '0) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected flag", 32'(rose), 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R5 flag buffer", 32'(rose), 32'(1) << e.idx);
                check("R10 flag latency", 32'(cyc), 32'(e.at));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        rd_check("R1 code mb0", 6'h00, 32'h0);
        rd_check("R1 iflag", 6'h21, 32'h0);
        rd_check("R1 mask", 6'h20, 32'h1FFF_FFFF);
        check("R1 irq port", 32'(irq_flags), 32'h0);

        // R2: configure buffers 0 (parked), 1, 2 (std 0x123), 3 (ext).
        host_wr(6'h00, 32'h0); host_wr(6'h01, 32'h123);
        for (int b = 1; b <= 2; b++) begin
            host_wr(6'(4*b), 32'h0); host_wr(6'(4*b+1), 32'h123); host_wr(6'(4*b), 32'h4);
        end
        host_wr(6'h0C, 32'h0); host_wr(6'h0D, 32'h81AB_CDEF); host_wr(6'h0C, 32'h4);
        rd_check("R2 id word mb1", 6'h05, 32'h0000_0123);
        rd_check("R2 id word mb3", 6'h0D, 32'h81AB_CDEF);
        rd_check("R2 ctrl mb2", 6'h08, 32'h4);

        // Frame A: parked mb0 skipped (R3), lowest enabled mb1 wins (R5).
        send_frame(1'b0, 29'h123, 4'd8, 64'h1122_3344_5566_7788, 16'hBEEF, 1);
        rd_check("R6 R7 ctrl mb1 full", 6'h04, 32'hBEEF_0802);
        rd_check("R6 data lo mb1", 6'h06, 32'h5566_7788);
        rd_check("R6 data hi mb1", 6'h07, 32'h1122_3344);
        rd_check("R3 parked mb0 untouched", 6'h00, 32'h0);
        rd_check("R5 mb2 untouched", 6'h08, 32'h4);
        rd_check("R8 iflag", 6'h21, 32'h2);

        // R9: write-one clear, write-zero no effect.
        host_wr(6'h21, 32'h0);
        rd_check("R9 zero write keeps", 6'h21, 32'h2);
        host_wr(6'h21, 32'h2);
        rd_check("R9 one write clears", 6'h21, 32'h0);

        // Frame B: full mb1 receives again -> overrun (R7).
        send_frame(1'b0, 29'h123, 4'd2, 64'hAB, 16'h0101, 1);
        rd_check("R7 ctrl mb1 overrun", 6'h04, 32'h0101_0206);

        // Frames C, D: no match (wrong id; right id bits, wrong format) (R8, R4).
        send_frame(1'b0, 29'h124, 4'd1, 64'h1, 16'h7777, -1);
        send_frame(1'b0, 29'h1AB_CDEF, 4'd1, 64'h2, 16'h7778, -1);
        rd_check("R8 no-match flags", 6'h21, 32'h2);
        rd_check("R8 no-match mb1", 6'h04, 32'h0101_0206);
        rd_check("R4 format mismatch mb3", 6'h0C, 32'h4);

        // Frame E: masked low nibble, ext match, id overwritten (R4, R6).
        host_wr(6'h20, 32'h1FFF_FFF0);
        rd_check("R2 mask readback", 6'h20, 32'h1FFF_FFF0);
        send_frame(1'b1, 29'h1AB_CDE5, 4'd1, 64'h5A, 16'h0033, 3);
        rd_check("R6 masked id stored mb3", 6'h0D, 32'h81AB_CDE5);
        rd_check("R4 ctrl mb3", 6'h0C, 32'h0033_0102);
        rd_check("R8 iflag two bits", 6'h21, 32'hA);

        // Frame F: park mb1 again, masked std id lands in mb2 (R3, R5).
        host_wr(6'h04, 32'h0);
        host_wr(6'h21, 32'hA);
        send_frame(1'b0, 29'h12A, 4'd0, 64'h0, 16'h0404, 2);
        rd_check("R3 ctrl mb2 full", 6'h08, 32'h0404_0002);
        rd_check("R3 parked mb1 kept", 6'h04, 32'h0101_0200);
        rd_check("R8 iflag mb2", 6'h21, 32'h4);

        check("R8 all expected flags seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule